// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes a serial audio stream made of a bit clock, a frame clock and one data line, and turns each received word into a parallel sample. A single shift engine serves five framings: three two-channel layouts (I2S, left-justified, right-justified) and time-division multiplexed frames of 8 or 16 slots. In every framing the word length can be 16, 20 or 24 bits. The word arrives MSB first in twos complement.

The serial pins are sampled in the system clock domain through a short synchronizer. Each rising edge of the bit clock is one serial bit. A counter measures the bit position since the last frame edge, and a per-mode MSB offset opens a capture window of exactly one word. Each finished word is left-aligned into a 28-bit fixed-point sample with 5 integer bits and 23 fraction bits, and carries a channel index.

Samples leave on a valid/ready stream. The stream does not apply back-pressure towards the serial side: a single holding register keeps the current sample until it is accepted. Any word that completes while that register is still occupied is dropped, because the serial line cannot be paused. The system clock must run at least four times faster than the bit clock, so that each bit-clock phase lasts at least two system cycles.

Top module: `serial_audio_rx`

## Requirements
- R1: After reset `out_valid` is low, and no sample is produced until a frame edge has been seen after reset.
- R2: With `fmt_sel`=0 (I2S), the first bit captured after a frame-clock change is ignored and the MSB follows on the next bit. The channel is 0 while the frame clock is low and 1 while it is high.
- R3: With `fmt_sel`=1 (left-justified), the MSB is the first bit sampled with the new frame-clock level. The channel is 0 while the frame clock is high and 1 while it is low.
- R4: With `fmt_sel`=2 (right-justified), the MSB sits 32 minus the word length bits after the frame edge, so the LSB is bit 31 of the 32-bit half-frame. The channel rule is the same as in R3.
- R5: `wlen_sel` 0, 1 and 2 (3 acts as 2) select 16, 20 and 24 data bits in every framing. Bits outside the word window have no effect on the sample.
- R6: `out_sample` holds the word with its MSB at bit 23 and zeros below the LSB. Bits 27:24 repeat bit 23.
- R7: With `fmt_sel`=3 (8 slots) or 4 (16 slots), a rising frame-clock edge starts slot 0. Slot k occupies bits 32k to 32k+31 of the frame and carries its MSB at bit 32k. `out_chan` is k. Bits after the last slot are ignored until the next rising edge.
- R8: A frame edge that arrives before the current word is complete discards the partial word. The new half-frame or frame is then decoded normally.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sample` and `out_chan` stay unchanged. A word that completes in that state is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fmt_sel | input | 3 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 TDM 8 slots, 4 TDM 16 slots, others capture nothing |
| wlen_sel | input | 2 | Word length: 0 16-bit, 1 20-bit, 2 or 3 24-bit |
| bit_clk | input | 1 | Serial bit clock, asynchronous to clk |
| frame_clk | input | 1 | Left/right clock, or frame sync in TDM |
| ser_data | input | 1 | Serial data, MSB first |
| out_valid | output | 1 | Sample available |
| out_ready | input | 1 | Consumer accepts the sample on this clock |
| out_sample | output | 28 | Sign-extended sample, 5.23 format |
| out_chan | output | 4 | Channel or slot index of the sample |

## Verification
Two situations are hard to reach from the ports. The first is a frame that ends in the middle of a word. The stimulus produces it by cutting a half-frame or a TDM frame short after a chosen number of bits and then starting the next frame at once, so that one slot is complete and the next one is partial. The second is a word dropped under back-pressure, which needs the consumer to stall for the whole length of a later word. The bench holds `out_ready` low across a full two-channel frame and then checks that only the first word comes out. Short periodic stalls during the TDM runs exercise the hold rule without losing any words.

// File: rtl/sai_pkg.sv
package sai_pkg;

  typedef enum logic [2:0] {
    FMT_I2S   = 3'd0,
    FMT_LEFT  = 3'd1,
    FMT_RIGHT = 3'd2,
    FMT_TDM8  = 3'd3,
    FMT_TDM16 = 3'd4
  } fmt_e;

  // data bits carried for a word-length code
  function automatic logic [5:0] word_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd16;
      2'd1:    return 6'd20;
      default: return 6'd24;
    endcase
  endfunction

  // bit position of the MSB inside a half-frame or slot
  function automatic logic [5:0] msb_offset(input fmt_e fmt, input logic [5:0] bits,
                                            input logic [5:0] slot_len);
    case (fmt)
      FMT_I2S:   return 6'd1;
      FMT_RIGHT: return slot_len - bits;
      default:   return 6'd0;
    endcase
  endfunction

endpackage

// File: rtl/sai_bit_sampler.sv
module sai_bit_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_in,
  input  logic lr_in,
  input  logic dat_in,
  output logic tick,
  output logic lr_s,
  output logic dat_s
);
  localparam int CW = 3 * SYNC_STAGES;

  logic [CW-1:0] chain_q;
  logic          bclk_last_q;
  logic [2:0]    tail;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {bclk_in, lr_in, dat_in};
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[CW-4:0], bclk_in, lr_in, dat_in};
      end
    end
  endgenerate

  assign tail = chain_q[CW-1:CW-3];

  always_ff @(posedge clk) begin
    if (rst) bclk_last_q <= 1'b0;
    else     bclk_last_q <= tail[2];
  end

  assign tick  = tail[2] & ~bclk_last_q;
  assign lr_s  = tail[1];
  assign dat_s = tail[0];

endmodule

// File: rtl/sai_frame_tracker.sv
module sai_frame_tracker
  import sai_pkg::*;
#(
  parameter int SLOT_BITS   = 32,
  parameter int MAX_SLOTS   = 16,
  parameter int SMALL_SLOTS = 8,
  localparam int SLOT_W     = $clog2(SLOT_BITS),
  localparam int CHAN_W     = $clog2(MAX_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              lr,
  input  fmt_e              fmt,
  output logic              win,
  output logic [SLOT_W-1:0] slot_bit,
  output logic [CHAN_W-1:0] chan
);
  localparam int TOTAL = MAX_SLOTS * SLOT_BITS;
  localparam int POS_W = $clog2(TOTAL + 1);

  logic              prev_valid_q, lr_prev_q, active_q;
  logic [POS_W-1:0]  pos_q, cur_pos, frame_len;
  logic              fmt_ok, two_ch, is_tdm, frame_edge, in_win;

  always_comb begin
    fmt_ok    = 1'b1;
    two_ch    = 1'b1;
    frame_len = POS_W'(SLOT_BITS);
    case (fmt)
      FMT_I2S, FMT_LEFT, FMT_RIGHT: ;
      FMT_TDM8: begin
        two_ch    = 1'b0;
        frame_len = POS_W'(SMALL_SLOTS * SLOT_BITS);
      end
      FMT_TDM16: begin
        two_ch    = 1'b0;
        frame_len = POS_W'(TOTAL);
      end
      default: begin
        fmt_ok    = 1'b0;
        frame_len = '0;
      end
    endcase
  end

  assign is_tdm     = ~two_ch;
  // TDM: rising edge is a frame sync; two-channel: any level change
  assign frame_edge = tick & prev_valid_q &
                      (is_tdm ? (lr & ~lr_prev_q) : (lr ^ lr_prev_q));
  assign cur_pos    = frame_edge ? '0 : pos_q;
  assign in_win     = fmt_ok & (active_q | frame_edge) & (cur_pos < frame_len);
  assign win        = tick & in_win;
  assign slot_bit   = cur_pos[SLOT_W-1:0];

  always_comb begin
    if (two_ch)
      chan = {{(CHAN_W-1){1'b0}}, (fmt == FMT_I2S) ? lr : ~lr};
    else
      chan = cur_pos[SLOT_W+CHAN_W-1:SLOT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_valid_q <= 1'b0;
      lr_prev_q    <= 1'b0;
      active_q     <= 1'b0;
      pos_q        <= '0;
    end else if (tick) begin
      prev_valid_q <= 1'b1;
      lr_prev_q    <= lr;
      if (frame_edge) active_q <= 1'b1;
      if (in_win)     pos_q <= cur_pos + POS_W'(1);
      else if (frame_edge) pos_q <= '0;
    end
  end

  assert_pos_bound_R7: assert property (@(posedge clk) disable iff (rst)
    pos_q <= POS_W'(TOTAL));

  assert_idle_before_edge_R1: assert property (@(posedge clk) disable iff (rst)
    !prev_valid_q |-> !active_q);

endmodule

// File: rtl/sai_word_shifter.sv
module sai_word_shifter
  import sai_pkg::*;
#(
  parameter int SLOT_BITS   = 32,
  parameter int FRAC_W      = 23,
  parameter int SAMPLE_W    = 28,
  parameter int MAX_SLOTS   = 16,
  parameter int SMALL_SLOTS = 8,
  localparam int SLOT_W     = $clog2(SLOT_BITS),
  localparam int CHAN_W     = $clog2(MAX_SLOTS),
  localparam int WORD_MAX   = FRAC_W + 1,
  localparam int OFF_W      = SLOT_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                win,
  input  logic [SLOT_W-1:0]   slot_bit,
  input  logic                dat,
  input  logic [CHAN_W-1:0]   chan_in,
  input  fmt_e                fmt,
  input  logic [1:0]          wlen,
  output logic                done_q,
  output logic [SAMPLE_W-1:0] sample_q,
  output logic [CHAN_W-1:0]   chan_q
);
  logic [OFF_W-1:0]    w_len, off, pos, shamt;
  logic                in_word, last;
  logic [WORD_MAX-1:0] sreg_q, sreg_nx, aligned;
  logic [SAMPLE_W-1:0] fmt_sample;
  logic [CHAN_W:0]     chan_lim;

  assign w_len   = OFF_W'(word_bits(wlen));
  assign off     = OFF_W'(msb_offset(fmt, word_bits(wlen), 6'(SLOT_BITS)));
  assign pos     = {1'b0, slot_bit};
  assign in_word = win & (pos >= off) & (pos < off + w_len);
  assign last    = in_word & (pos == off + w_len - OFF_W'(1));

  // shift exactly w_len bits; stale upper bits fall off when aligned
  assign sreg_nx    = {sreg_q[WORD_MAX-2:0], dat};
  assign shamt      = OFF_W'(WORD_MAX) - w_len;
  assign aligned    = sreg_nx << shamt;
  assign fmt_sample = {{(SAMPLE_W-WORD_MAX){aligned[WORD_MAX-1]}}, aligned};

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q   <= '0;
      done_q   <= 1'b0;
      sample_q <= '0;
      chan_q   <= '0;
    end else begin
      done_q <= last;
      if (in_word) sreg_q <= sreg_nx;
      if (last) begin
        sample_q <= fmt_sample;
        chan_q   <= chan_in;
      end
    end
  end

  always_comb begin
    case (fmt)
      FMT_TDM8:  chan_lim = (CHAN_W+1)'(SMALL_SLOTS);
      FMT_TDM16: chan_lim = (CHAN_W+1)'(MAX_SLOTS);
      default:   chan_lim = (CHAN_W+1)'(2);
    endcase
  end

  assert_chan_in_range_R7: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ({1'b0, chan_q} < chan_lim));

  assert_word_spacing_R5: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

endmodule

// File: rtl/sai_out_hold.sv
module sai_out_hold #(
  parameter int SAMPLE_W = 28,
  parameter int CHAN_W   = 4,
  parameter int SIGN_RUN = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                done,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic [CHAN_W-1:0]   chan_in,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_sample,
  output logic [CHAN_W-1:0]   out_chan
);
  logic free;
  assign free = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
      out_chan   <= '0;
    end else if (free) begin
      out_valid <= done;
      if (done) begin
        out_sample <= sample_in;
        out_chan   <= chan_in;
      end
    end
  end

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample) && $stable(out_chan)));

  assert_sign_ext_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones(out_sample[SAMPLE_W-1:SAMPLE_W-SIGN_RUN]) == 0 ||
                   $countones(out_sample[SAMPLE_W-1:SAMPLE_W-SIGN_RUN]) == SIGN_RUN));

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> !out_valid);

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sai_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SLOT_BITS   = 32,
  parameter int MAX_SLOTS   = 16,
  parameter int SMALL_SLOTS = 8,
  parameter int FRAC_W      = 23,
  parameter int SAMPLE_W    = 28,
  localparam int CHAN_W     = $clog2(MAX_SLOTS),
  localparam int SLOT_W     = $clog2(SLOT_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          fmt_sel,
  input  logic [1:0]          wlen_sel,
  input  logic                bit_clk,
  input  logic                frame_clk,
  input  logic                ser_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_sample,
  output logic [CHAN_W-1:0]   out_chan
);
  fmt_e                fmt;
  logic                tick, lr_s, dat_s, win, done;
  logic [SLOT_W-1:0]   slot_bit;
  logic [CHAN_W-1:0]   trk_chan, word_chan;
  logic [SAMPLE_W-1:0] word_sample;

  assign fmt = fmt_e'(fmt_sel);

  sai_bit_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst(rst), .bclk_in(bit_clk), .lr_in(frame_clk), .dat_in(ser_data),
    .tick(tick), .lr_s(lr_s), .dat_s(dat_s)
  );

  sai_frame_tracker #(
    .SLOT_BITS(SLOT_BITS), .MAX_SLOTS(MAX_SLOTS), .SMALL_SLOTS(SMALL_SLOTS)
  ) u_tracker (
    .clk(clk), .rst(rst), .tick(tick), .lr(lr_s), .fmt(fmt),
    .win(win), .slot_bit(slot_bit), .chan(trk_chan)
  );

  sai_word_shifter #(
    .SLOT_BITS(SLOT_BITS), .FRAC_W(FRAC_W), .SAMPLE_W(SAMPLE_W),
    .MAX_SLOTS(MAX_SLOTS), .SMALL_SLOTS(SMALL_SLOTS)
  ) u_shifter (
    .clk(clk), .rst(rst), .win(win), .slot_bit(slot_bit), .dat(dat_s),
    .chan_in(trk_chan), .fmt(fmt), .wlen(wlen_sel),
    .done_q(done), .sample_q(word_sample), .chan_q(word_chan)
  );

  sai_out_hold #(
    .SAMPLE_W(SAMPLE_W), .CHAN_W(CHAN_W), .SIGN_RUN(SAMPLE_W - FRAC_W)
  ) u_hold (
    .clk(clk), .rst(rst), .done(done), .sample_in(word_sample), .chan_in(word_chan),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sample(out_sample), .out_chan(out_chan)
  );

endmodule

// File: tb/serial_audio_rx_bench.sv
`timescale 1ns/100ps
module serial_audio_rx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  fmt_sel = 3'd0;
  logic [1:0]  wlen_sel = 2'd2;
  logic        bit_clk = 1'b0, frame_clk = 1'b0, ser_data = 1'b0;
  logic        out_valid, out_ready;
  logic [27:0] out_sample;
  logic [3:0]  out_chan;

  int checks = 0, failures = 0, cyc = 0;
  bit stall_hold = 0, stall_toggle = 0, finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          hold_prev = 0;
  logic [31:0] hold_data;

  always #2 clk = ~clk;

  serial_audio_rx u_serial_audio_rx (
    .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .wlen_sel(wlen_sel),
    .bit_clk(bit_clk), .frame_clk(frame_clk), .ser_data(ser_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sample(out_sample), .out_chan(out_chan)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // sign-extend a w-bit word, scale to MSB at bit 23, keep 28 bits
  function automatic logic [27:0] fmt28(input int val, input int w);
    longint s;
    s = longint'(val) & ((64'sd1 << w) - 1);
    if (s >= (64'sd1 << (w - 1))) s = s - (64'sd1 << w);
    s = s * (64'sd1 << (24 - w));
    return s[27:0];
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (stall_hold) out_ready = 1'b0;
    else if (stall_toggle) out_ready = (cyc % 4) != 0;
    else out_ready = 1'b1;
  end

  // per-clock comparison against the expected-sample queue
  always begin
    @(negedge clk);
    #1;
    if (rst) hold_prev = 0;
    else begin
      if (hold_prev)
        chk(out_valid && {out_chan, out_sample} == hold_data, "R9 held sample changed",
            {out_valid, out_chan[2:0], out_sample}, hold_data);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0)
          chk(0, "R8 unexpected sample", {out_chan, out_sample}, 32'h0);
        else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({out_chan, out_sample} == e, t, {out_chan, out_sample}, e);
        end
      end
      hold_prev = out_valid && !out_ready;
      hold_data = {out_chan, out_sample};
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic send_bit(input bit lr, input bit d);
    @(negedge clk);
    bit_clk = 1'b0; frame_clk = lr; ser_data = d;
    @(negedge clk);
    @(negedge clk);
    bit_clk = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_reset(input int fmt, input int w);
    @(negedge clk);
    rst = 1'b1;
    fmt_sel = 3'(fmt);
    wlen_sel = (w == 16) ? 2'd0 : (w == 20) ? 2'd1 : 2'd2;
    bit_clk = 1'b0; frame_clk = 1'b0; ser_data = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R1 reset state", {31'b0, out_valid}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic preamble(input bit lr, input int n);
    for (int p = 0; p < n; p++) send_bit(lr, 1'b1);
  endtask

  task automatic half2(input int fmt, input int w, input bit lr, input int val,
                       input int nbits, input bit push, input string tag);
    int off;
    off = (fmt == 0) ? 1 : (fmt == 1) ? 0 : 32 - w;
    if (push && nbits == 32) begin
      bit ch;
      ch = (fmt == 0) ? lr : !lr;
      exp_q.push_back({3'b0, ch, fmt28(val, w)});
      tag_q.push_back(tag);
    end
    for (int p = 0; p < nbits; p++) begin
      bit d;
      if (p >= off && p < off + w) d = bit'((val >> (w - 1 - (p - off))) & 1);
      else d = (p % 3) == 0;
      send_bit(lr, d);
    end
  endtask

  task automatic tdm_frame(input int slots, input int w, input int vals[16],
                           input int nbits, input int trailer, input string tag);
    for (int k = 0; k < slots; k++)
      if (nbits >= 32 * k + w) begin
        exp_q.push_back({k[3:0], fmt28(vals[k], w)});
        tag_q.push_back(tag);
      end
    for (int p = 0; p < nbits; p++) begin
      int s, q;
      bit d;
      s = p / 32; q = p % 32;
      if (q < w) d = bit'((vals[s] >> (w - 1 - q)) & 1);
      else d = (q % 3) == 0;
      send_bit(p == 0, d);
    end
    for (int p = 0; p < trailer; p++) send_bit(1'b0, 1'b1);
  endtask

  task automatic drain(input string tag);
    repeat (40) @(negedge clk);
    #1;
    chk(exp_q.size() == 0, tag, exp_q.size(), 32'h0);
  endtask

  initial begin
    int tv[16];
    for (int k = 0; k < 16; k++) tv[k] = 32'h5A3C1 * (k + 3) ^ (k << 19);

    // R1 and R2: I2S, 24-bit
    do_reset(0, 24);
    preamble(1'b1, 32);
    repeat (10) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R1 no sample before first edge", {31'b0, out_valid}, 32'h0);
    half2(0, 24, 1'b0, 'h800000, 32, 1, "R2 R6 i2s left min");
    half2(0, 24, 1'b1, 'h7FFFFF, 32, 1, "R2 R6 i2s right max");
    half2(0, 24, 1'b0, 'h123456, 32, 1, "R2 i2s left");
    half2(0, 24, 1'b1, 'hFEDCBA, 32, 1, "R2 i2s right neg");
    drain("R2 i2s all samples seen");

    // R5: I2S, 16-bit
    do_reset(0, 16);
    preamble(1'b1, 32);
    half2(0, 16, 1'b0, 'h8001, 32, 1, "R5 R6 i2s 16-bit left");
    half2(0, 16, 1'b1, 'h1234, 32, 1, "R5 i2s 16-bit right");
    drain("R5 i2s 16-bit drained");

    // R3: left-justified, 20-bit
    do_reset(1, 20);
    preamble(1'b0, 32);
    half2(1, 20, 1'b1, 'hA5A5A, 32, 1, "R3 R5 lj left");
    half2(1, 20, 1'b0, 'h5A5A5, 32, 1, "R3 lj right");
    half2(1, 20, 1'b1, 'h00001, 32, 1, "R3 lj left small");
    drain("R3 lj drained");

    // R4: right-justified in each length
    do_reset(2, 16);
    preamble(1'b0, 32);
    half2(2, 16, 1'b1, 'hC001, 32, 1, "R4 rj16 left");
    half2(2, 16, 1'b0, 'h7FFE, 32, 1, "R4 rj16 right");
    drain("R4 rj16 drained");
    do_reset(2, 24);
    preamble(1'b0, 32);
    half2(2, 24, 1'b1, 'h876543, 32, 1, "R4 rj24 left");
    half2(2, 24, 1'b0, 'h0F0F0F, 32, 1, "R4 rj24 right");
    drain("R4 rj24 drained");
    do_reset(2, 20);
    preamble(1'b0, 32);
    half2(2, 20, 1'b1, 'h80000, 32, 1, "R4 R5 rj20 left");
    half2(2, 20, 1'b0, 'h3C3C3, 32, 1, "R4 rj20 right");
    drain("R4 rj20 drained");

    // R8: short half-frame in left-justified mode
    do_reset(1, 24);
    preamble(1'b0, 32);
    half2(1, 24, 1'b1, 'h111111, 32, 1, "R8 lj before cut");
    half2(1, 24, 1'b0, 'h222222, 10, 0, "R8 cut");
    half2(1, 24, 1'b1, 'h333333, 32, 1, "R8 lj after resync left");
    half2(1, 24, 1'b0, 'hC44444, 32, 1, "R8 lj after resync right");
    drain("R8 partial word dropped");

    // R7: 8-slot TDM, 24-bit, with short stalls and trailing bits
    do_reset(3, 24);
    stall_toggle = 1;
    preamble(1'b0, 4);
    tdm_frame(8, 24, tv, 256, 40, "R7 tdm8 slot");
    tdm_frame(8, 24, tv, 256, 3, "R7 tdm8 second frame");
    drain("R7 tdm8 trailer ignored");
    stall_toggle = 0;

    // R7: 16-slot TDM, 16-bit
    do_reset(4, 16);
    preamble(1'b0, 4);
    tdm_frame(16, 16, tv, 512, 2, "R7 R5 tdm16 slot");
    drain("R7 tdm16 drained");

    // R8: TDM frame cut inside slot 1
    do_reset(4, 20);
    preamble(1'b0, 4);
    tdm_frame(16, 20, tv, 44, 0, "R8 tdm cut frame slot");
    tdm_frame(16, 20, tv, 512, 2, "R8 tdm resync slot");
    drain("R8 tdm partial slot dropped");

    // R9: long stall drops the newer word
    do_reset(1, 24);
    stall_hold = 1;
    preamble(1'b0, 32);
    half2(1, 24, 1'b1, 'hABCDEF, 32, 1, "R9 held left");
    half2(1, 24, 1'b0, 'h13579B, 32, 0, "R9 dropped");
    repeat (10) @(negedge clk);
    #1;
    chk(out_valid && {out_chan, out_sample} == {4'd0, fmt28('hABCDEF, 24)},
        "R9 first word kept", {out_chan, out_sample}, {4'd0, fmt28('hABCDEF, 24)});
    stall_hold = 0;
    drain("R9 second word dropped");
    repeat (5) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R9 nothing left after stall", {31'b0, out_valid}, 32'h0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule